// File: doc/BRIEF.md
# Multiply and Shift Product Unit

This block keeps a 32-bit signed product in two 16-bit halves, a high word and a low word, and updates it with one of eight arithmetic operations. It can form a fresh product from an operand and an accumulator value, multiply the held product again by a 16-bit operand, or shift the held product arithmetically left or right. Saturating forms of the multiply and shift clamp the result to the signed 32-bit range instead of letting it wrap.

A request is presented for one cycle with `start` high together with the opcode, the operand, the accumulator value and the shift count. The product halves take the new value at that clock edge and `done` is high for the following cycle. Either half may also be loaded directly through `wr_hi`/`wr_lo` with `wr_data`, and both halves are always visible on the outputs. The unit holds no arithmetic flags and changes none.

Top module: `mps_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) both product halves read 0 and `done` is low.
- R2: With `start` low, `wr_hi` loads `wr_data` into the high half and `wr_lo` loads it into the low half at the clock edge; a half whose write strobe is low keeps its value.
- R3: Opcode 0 loads the product with the signed 32-bit product of `operand` and `acc`.
- R4: Opcode 1 loads the product with twice the signed product of `operand` and `acc` (fractional form); when both are 0x8000 the result is clamped to 0x7FFFFFFF.
- R5: Opcode 2 multiplies the held 32-bit signed product by the signed `operand` and keeps the low 32 bits of the 48-bit result.
- R6: Opcode 3 multiplies as in opcode 2 but clamps the result to 0x7FFFFFFF or 0x80000000 when it lies outside the signed 32-bit range.
- R7: Opcode 4 shifts the product left by `shamt` (0..31): bit 31 keeps the old sign, the low `shamt` bits become 0, the other bits take the shifted value.
- R8: Opcode 5 shifts the product right arithmetically by `shamt`, copying the sign into the vacated upper bits.
- R9: Opcode 6 shifts left by `shamt`; if the exact result does not fit in signed 32 bits it becomes 0x7FFFFFFF for a positive product and 0x80000000 for a negative one, otherwise it is the exact shifted value.
- R10: Opcode 7 gives the same result as opcode 5, since a right shift cannot leave the signed range.
- R11: `done` is high in exactly the cycle after a cycle with `start` high; without `start` or a write strobe the product does not change.
- R12: When `start` and a write strobe are high in the same cycle, the operation result is stored and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an operation this cycle |
| op | input | 3 | Operation code (0..7) |
| operand | input | 16 | Signed multiplier operand (register or immediate) |
| acc | input | 16 | Signed accumulator value |
| shamt | input | 5 | Shift count 0..31 |
| wr_hi | input | 1 | Direct write of the high half |
| wr_lo | input | 1 | Direct write of the low half |
| wr_data | input | 16 | Data for direct writes |
| prod_hi | output | 16 | High half of the product |
| prod_lo | output | 16 | Low half of the product |
| done | output | 1 | Operation completed in the previous edge |

## Verification
Assertions watch on every cycle that `done` follows `start` by one cycle, that an idle cycle leaves the product alone, that a plain left shift zero-fills the low bits and keeps the sign, that a right shift keeps the sign, and that a saturating result never flips the sign of a shifted product. The numeric correctness of each multiply, the exact clamp values, the fractional corner at 0x8000 times 0x8000 and the priority of an operation over a simultaneous write can only be shown by the bench scenarios compared against its reference model.

// File: rtl/mps_pkg.sv
// Package: shared operation codes for the multiply and shift product unit.
// Assumes: codes are decoded by the surrounding core and held for one cycle.
package mps_pkg;
    typedef enum logic [2:0] {
        OP_MUL_OA     = 3'd0,
        OP_MUL_OA_FRS = 3'd1,
        OP_MUL_PO     = 3'd2,
        OP_MUL_PO_SAT = 3'd3,
        OP_SHL        = 3'd4,
        OP_SHR        = 3'd5,
        OP_SHL_SAT    = 3'd6,
        OP_SHR_SAT    = 3'd7
    } mps_op_e;
endpackage

// File: rtl/mps_mul.sv
// Module: mps_mul
// Combinational multiply paths. Forms operand*acc (plain and fractional
// saturating) and product*operand (wrapping and saturating), selected by op.
// Assumes: all inputs are two's complement; WORD_W >= 2.
module mps_mul #(
    parameter int WORD_W = 16
) (
    input  mps_pkg::mps_op_e       op,
    input  logic [2*WORD_W-1:0]    prod,
    input  logic [WORD_W-1:0]      operand,
    input  logic [WORD_W-1:0]      acc,
    output logic [2*WORD_W-1:0]    result
);
    localparam int PW = 2 * WORD_W;
    localparam int XW = 3 * WORD_W;

    logic signed [PW-1:0] oa_prod;
    logic signed [XW-1:0] po_prod;
    logic                 both_min;
    logic                 po_fits;
    logic [PW-1:0]        max_pos;
    logic [PW-1:0]        max_neg;

    assign oa_prod  = $signed(operand) * $signed(acc);
    assign po_prod  = $signed(prod) * $signed(operand);
    assign both_min = (operand == {1'b1, {(WORD_W-1){1'b0}}}) &&
                      (acc     == {1'b1, {(WORD_W-1){1'b0}}});
    assign po_fits  = (&po_prod[XW-1:PW-1]) || ~(|po_prod[XW-1:PW-1]);
    assign max_pos  = {1'b0, {(PW-1){1'b1}}};
    assign max_neg  = {1'b1, {(PW-1){1'b0}}};

    // Purpose: pick the multiply flavour requested by the opcode.
    always_comb begin
        unique case (op)
            mps_pkg::OP_MUL_OA:     result = oa_prod;
            mps_pkg::OP_MUL_OA_FRS: result = both_min ? max_pos : {oa_prod[PW-2:0], 1'b0};
            mps_pkg::OP_MUL_PO:     result = po_prod[PW-1:0];
            mps_pkg::OP_MUL_PO_SAT: result = po_fits ? po_prod[PW-1:0]
                                           : (po_prod[XW-1] ? max_neg : max_pos);
            default:                result = prod;
        endcase
    end
endmodule

// File: rtl/mps_shift.sv
// Module: mps_shift
// Barrel shifter for the product: sign-keeping left shift, arithmetic right
// shift, and a saturating left shift that clamps when the exact value does
// not fit. Built as log2 stages by a generate loop.
// Assumes: shamt ranges over 0..2*WORD_W-1.
module mps_shift #(
    parameter int WORD_W = 16,
    parameter int SH_W   = $clog2(2 * WORD_W)
) (
    input  mps_pkg::mps_op_e       op,
    input  logic [2*WORD_W-1:0]    prod,
    input  logic [SH_W-1:0]        shamt,
    output logic [2*WORD_W-1:0]    result
);
    localparam int PW = 2 * WORD_W;
    localparam int LW = 2 * PW;

    logic [LW-1:0] lst [0:SH_W];
    logic [PW-1:0] rst_stage [0:SH_W];
    logic [LW-1:0] left_full;
    logic [PW-1:0] right_res;
    logic [PW-1:0] left_plain;
    logic [PW-1:0] left_sat;
    logic          left_fits;

    assign lst[0]       = {{PW{prod[PW-1]}}, prod};
    assign rst_stage[0] = prod;

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            assign lst[k+1]       = shamt[k] ? (lst[k] << (1 << k)) : lst[k];
            assign rst_stage[k+1] = shamt[k] ? PW'($signed(rst_stage[k]) >>> (1 << k))
                                             : rst_stage[k];
        end
    endgenerate

    assign left_full  = lst[SH_W];
    assign right_res  = rst_stage[SH_W];
    assign left_plain = {prod[PW-1], left_full[PW-2:0]};
    assign left_fits  = (&left_full[LW-1:PW-1]) || ~(|left_full[LW-1:PW-1]);
    assign left_sat   = left_fits ? left_full[PW-1:0]
                      : (prod[PW-1] ? {1'b1, {(PW-1){1'b0}}} : {1'b0, {(PW-1){1'b1}}});

    // Purpose: pick the shift flavour requested by the opcode.
    always_comb begin
        unique case (op)
            mps_pkg::OP_SHL:     result = left_plain;
            mps_pkg::OP_SHL_SAT: result = left_sat;
            mps_pkg::OP_SHR,
            mps_pkg::OP_SHR_SAT: result = right_res;
            default:             result = prod;
        endcase
    end
endmodule

// File: rtl/mps_unit.sv
// Module: mps_unit (top)
// Holds the 32-bit product in two halves and updates it with a multiply or
// shift when start is high, or by direct half-word writes otherwise.
// Assumes: one request per cycle; operation has priority over writes.
module mps_unit #(
    parameter int WORD_W = 16,
    parameter int SH_W   = $clog2(2 * WORD_W),
    parameter int OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] acc,
    input  logic [SH_W-1:0]   shamt,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] prod_hi,
    output logic [WORD_W-1:0] prod_lo,
    output logic              done
);
    localparam int PW = 2 * WORD_W;

    mps_pkg::mps_op_e op_e;
    logic [PW-1:0]    prod_q;
    logic [PW-1:0]    mul_res;
    logic [PW-1:0]    sh_res;
    logic [PW-1:0]    op_res;
    logic             done_q;

    assign op_e = mps_pkg::mps_op_e'(op);

    mps_mul #(.WORD_W(WORD_W)) i_mul (
        .op(op_e), .prod(prod_q), .operand(operand), .acc(acc), .result(mul_res)
    );

    mps_shift #(.WORD_W(WORD_W), .SH_W(SH_W)) i_shift (
        .op(op_e), .prod(prod_q), .shamt(shamt), .result(sh_res)
    );

    // Purpose: multiply opcodes have op[2]==0, shift opcodes op[2]==1.
    always_comb begin
        op_res = op[OP_W-1] ? sh_res : mul_res;
    end

    // Purpose: product register with operation-over-write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (start) begin
            prod_q <= op_res;
        end else begin
            if (wr_hi) prod_q[PW-1:WORD_W] <= wr_data;
            if (wr_lo) prod_q[WORD_W-1:0]  <= wr_data;
        end
    end

    // Purpose: completion pulse one cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= start;
    end

    assign prod_hi = prod_q[PW-1:WORD_W];
    assign prod_lo = prod_q[WORD_W-1:0];
    assign done    = done_q;

    // R11: done follows a request by exactly one cycle
    assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    assert_done_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R11: an idle cycle leaves the product untouched
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wr_hi && !wr_lo) |=> $stable({prod_hi, prod_lo}));

    // R7: plain left shift zero-fills the low bits and keeps the sign
    assert_shl_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd4) |=>
        ((({prod_hi, prod_lo}) & (({{(PW-1){1'b0}}, 1'b1} << $past(shamt)) - 1'b1)) == '0)
        && (prod_hi[WORD_W-1] == $past(prod_hi[WORD_W-1])));

    // R8: arithmetic right shift keeps the sign
    assert_shr_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 3'd5 || op == 3'd7)) |=>
        (prod_hi[WORD_W-1] == $past(prod_hi[WORD_W-1])));

    // R9: saturating left shift never flips the sign
    assert_shl_sat_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd6) |=>
        (prod_hi[WORD_W-1] == $past(prod_hi[WORD_W-1])));
endmodule

// File: tb/test_mps_unit.sv
`timescale 1ns/1ps
module test_mps_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] operand = '0;
    logic [15:0] acc = '0;
    logic [4:0]  shamt = '0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] prod_hi;
    logic [15:0] prod_lo;
    logic        done;

    int          vectors = 0;
    int          fails = 0;
    logic [31:0] m_prod = '0;
    logic        m_done = 1'b0;

    always #2.5 clk = ~clk;

    mps_unit i_mps_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .acc(acc), .shamt(shamt), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .done(done)
    );

    function automatic logic [31:0] clamp32(longint v);
        if (v > 64'sd2147483647)       return 32'h7FFF_FFFF;
        else if (v < -64'sd2147483648) return 32'h8000_0000;
        else                           return v[31:0];
    endfunction

    // Behavioural reference for one operation on the product p.
    function automatic logic [31:0] model(int code, logic [31:0] p, logic [15:0] o,
                                         logic [15:0] a, int n);
        longint ps = longint'($signed(p));
        longint os = longint'($signed(o));
        longint as_ = longint'($signed(a));
        longint v;
        case (code)
            0: begin v = os * as_; return v[31:0]; end
            1: begin
                if (o == 16'h8000 && a == 16'h8000) return 32'h7FFF_FFFF;
                v = os * as_ * 2; return v[31:0];
            end
            2: begin v = ps * os; return v[31:0]; end
            3: return clamp32(ps * os);
            4: begin v = ps <<< n; return {p[31], v[30:0]}; end
            6: return clamp32(ps <<< n);
            default: begin v = ps >>> n; return v[31:0]; end
        endcase
    endfunction

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input logic s, input int code, input logic [15:0] o,
                       input logic [15:0] a, input int n, input logic wh,
                       input logic wl, input logic [15:0] wd, input string req);
        start = s; op = code[2:0]; operand = o; acc = a; shamt = n[4:0];
        wr_hi = wh; wr_lo = wl; wr_data = wd;
        @(posedge clk);
        if (!rst_n) begin
            m_prod = '0; m_done = 1'b0;
        end else begin
            if (s) m_prod = model(code, m_prod, o, a, n);
            else begin
                if (wh) m_prod[31:16] = wd;
                if (wl) m_prod[15:0]  = wd;
            end
            m_done = s;
        end
        @(negedge clk);
        vectors++;
        if ({prod_hi, prod_lo} !== m_prod || done !== m_done) begin
            fails++;
            $display("FAIL %s: prod=%h done=%b expected prod=%h done=%b",
                     req, {prod_hi, prod_lo}, done, m_prod, m_done);
        end
    endtask

    task automatic load(input logic [31:0] v, input string req);
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b1, 1'b0, v[31:16], req);
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b1, v[15:0], req);
    endtask

    task automatic run(input int code, input logic [15:0] o, input logic [15:0] a,
                       input int n, input string req);
        cyc(1'b1, code, o, a, n, 1'b0, 1'b0, 16'h0, req);
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b0, 16'h0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b0, 16'h0, "R1 reset");
        cyc(1'b1, 0, 16'h7, 16'h9, 0, 1'b1, 1'b1, 16'hFFFF, "R1 reset ignores inputs");
        rst_n = 1'b1;
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b0, 16'h0, "R1 after reset");
        // R2 direct writes, one half at a time
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b1, 1'b0, 16'hABCD, "R2 write high");
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b1, 16'h1234, "R2 write low");
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b0, 16'h5555, "R11 idle hold");
        // R3 signed products
        run(0, 16'h0003, 16'h0005, 0, "R3 pos*pos");
        run(0, 16'hFFFD, 16'h0005, 0, "R3 neg*pos");
        run(0, 16'h8000, 16'h8000, 0, "R3 min*min");
        // R4 fractional saturating
        run(1, 16'h4000, 16'h4000, 0, "R4 half*half");
        run(1, 16'h8000, 16'h8000, 0, "R4 clamp");
        run(1, 16'h8000, 16'h7FFF, 0, "R4 min*max");
        // R5 and R6 product times operand
        load(32'h0001_0000, "R5 load");
        run(2, 16'h0010, 16'h0, 0, "R5 in range");
        load(32'h4000_0000, "R5 load");
        run(2, 16'h0004, 16'h0, 0, "R5 wrap");
        load(32'h4000_0000, "R6 load");
        run(3, 16'h0004, 16'h0, 0, "R6 clamp positive");
        load(32'h4000_0000, "R6 load");
        run(3, 16'hFFFC, 16'h0, 0, "R6 clamp negative");
        load(32'hFFFF_FFFE, "R6 load");
        run(3, 16'h0003, 16'h0, 0, "R6 in range");
        // R7 to R10 shifts
        load(32'h8000_0001, "R7 load");
        run(4, 16'h0, 16'h0, 4, "R7 sign kept");
        load(32'h1234_5678, "R7 load");
        run(4, 16'h0, 16'h0, 0, "R7 zero shift");
        load(32'hF000_0000, "R8 load");
        run(5, 16'h0, 16'h0, 31, "R8 full shift");
        load(32'h4000_0000, "R9 load");
        run(6, 16'h0, 16'h0, 1, "R9 clamp positive");
        load(32'hC000_0000, "R9 load");
        run(6, 16'h0, 16'h0, 1, "R9 exact negative");
        load(32'hA000_0000, "R9 load");
        run(6, 16'h0, 16'h0, 1, "R9 clamp negative");
        load(32'h0000_0003, "R9 load");
        run(6, 16'h0, 16'h0, 29, "R9 exact positive");
        load(32'h8765_4321, "R10 load");
        run(7, 16'h0, 16'h0, 8, "R10 sat right");
        // R12 operation beats a simultaneous write
        cyc(1'b1, 0, 16'h0002, 16'h0003, 0, 1'b1, 1'b1, 16'hDEAD, "R12 priority");
        // R11 back-to-back requests
        cyc(1'b1, 5, 16'h0, 16'h0, 1, 1'b0, 1'b0, 16'h0, "R11 back to back");
        cyc(1'b1, 4, 16'h0, 16'h0, 2, 1'b0, 1'b0, 16'h0, "R11 back to back");
        cyc(1'b0, 0, 16'h0, 16'h0, 0, 1'b0, 1'b0, 16'h0, "R11 done drop");
        // Mixed traffic across every opcode
        for (int i = 0; i < 400; i++) begin
            cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                16'($urandom), 16'($urandom), int'($urandom_range(0, 31)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'($urandom),
                "R3-R12 mixed");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule